// File: doc/BRIEF.md
# I2S Master Clock and Frame Generator

This block turns a single reference clock (nominally 32 MHz) into the three clocks that an I2S link needs when this side is the clock master. A programmable integer divider produces the master clock. The frame clock runs at the master-clock rate divided by a selectable oversampling ratio. The bit clock is placed so that every frame carries exactly twice the sample width in bits. Every output is a registered level in the reference-clock domain. No other clock domain is created.

The block also marks timing points for a data shifter placed next to it. A frame strobe marks the start of each frame. A word strobe marks the slot that holds the most significant bit of each active channel word. The configuration inputs are sampled only at frame boundaries, so the link never carries a partly old and partly new frame. An invalid setting is flagged at once and is never applied. When the master enable is low, the block is the clock slave: all counters hold in reset, the master clock is held low, and the output enables release the bit-clock and frame-clock pins so they can act as inputs.

Top module: `i2s_clkgen`

## Requirements
- R1: While reset is held low, every output is low: master clock, bit clock, frame clock, the three output enables and both strobes.
- R2: The divider code selects the master-clock period in reference cycles: 0→8, 1→10, 2→15, 3→16, 4→21, 5→32, 6→63, 7→125. Each frame contains exactly as many master-clock periods as the selected ratio.
- R3: For an even divisor N, the master clock is high for N/2 reference cycles and low for N/2. For an odd divisor, it is high for (N-1)/2 cycles and low for (N+1)/2.
- R4: The ratio code selects the ratio: 0→32, 1→48, 2→64, 3→96, 4→128, 5→192, 6→256, 7→384, 8→512. One frame lasts exactly divisor × ratio reference cycles, so the frame rate is the master-clock rate divided by the ratio. For example, divisor 32 with ratio 32 gives 31250 Hz.
- R5: The width code sets the sample width W: 0→8, 1→16, 2→24 bits. Each frame contains exactly 2W rising edges of the bit clock.
- R6: The frame clock is low for the first W bit slots of a frame and high for the last W. It changes only in a cycle where the bit clock is low. It rises on the falling bit-clock edge that begins slot W.
- R7: With the format input at 0 (I2S framing), the word strobe marks slot 1 for the left word and slot W+1 for the right word, which is one bit after each frame-clock change. With the format input at 1 (aligned framing), the strobe marks slot 0 and slot W, the same edges on which the frame clock changes.
- R8: The channel mode selects which words are strobed: 0 = stereo (both words), 1 = mono-left (left word only), 2 = mono-right (right word only).
- R9: The frame strobe is high for exactly one reference cycle. That cycle is the first cycle of each frame, in which the frame clock and bit clock are both low, directly after each falling edge of the frame clock.
- R10: A configuration change takes effect only at the next frame start. A change made during a frame, or in the frame-start cycle itself, leaves that frame's length and layout unchanged.
- R11: The bad-configuration flag is high whenever the inputs hold ratio code 9 to 15, width code 3, channel mode 3, or a ratio smaller than 2W. A bad configuration is never loaded, and the previous configuration continues to run.
- R12: When the master enable is low, from the next cycle onward the master clock is held low and all three output enables are low. When the enable returns high, a new frame starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_en_i | input | 1 | 1 = generate clocks (master), 0 = release pins (slave) |
| div_code_i | input | 3 | Master-clock divider code |
| ratio_code_i | input | 4 | Master-clock to frame-clock ratio code |
| width_code_i | input | 2 | Sample width code |
| chan_mode_i | input | 2 | Stereo / mono-left / mono-right |
| aligned_i | input | 1 | 0 = I2S framing, 1 = aligned framing |
| mck_o | output | 1 | Master clock |
| mck_oe_o | output | 1 | Master-clock output enable |
| sck_o | output | 1 | Bit clock |
| sck_oe_o | output | 1 | Bit-clock output enable |
| lrck_o | output | 1 | Frame (word-select) clock |
| lrck_oe_o | output | 1 | Frame-clock output enable |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |
| word_start_o | output | 1 | One-cycle strobe at the MSB slot of each active word |
| cfg_bad_o | output | 1 | Current configuration inputs are invalid |

## Verification
Two kinds of events can fall in the same reference cycle. The first is a frame-boundary reload together with a change on the configuration inputs, including a change to an invalid setting. The second, in aligned framing, is a left-word strobe together with the frame strobe. The bench changes the configuration in exactly the cycle where the frame strobe is seen, and also a few cycles into a frame. It then measures that the current frame keeps its old length and that the next frame has the new length. The aligned cases check that the left-word strobe falls at slot 0, in the same cycle as the frame strobe, while the I2S cases check that it falls one bit later.

// File: rtl/i2s_clkgen_pkg.sv
// Package: shared widths, configuration type and code decoders for the
// I2S clock generator. Assumes divisors up to 127 and ratios up to 512.
package i2s_clkgen_pkg;

    localparam int DIV_W   = 7;                 // widest divisor value (125)
    localparam int RATIO_W = 10;                // widest ratio value (512)
    localparam int WID_W   = 5;                 // widest sample width (24)
    localparam int FRAME_W = DIV_W + RATIO_W;   // reference cycles per frame
    localparam int HALF_W  = 7;                 // bit-clock half periods (<= 96)

    typedef enum logic [1:0] {
        CH_STEREO = 2'd0,
        CH_LEFT   = 2'd1,
        CH_RIGHT  = 2'd2,
        CH_RSVD   = 2'd3
    } chan_e;

    typedef struct packed {
        logic [2:0] div_code;
        logic [3:0] ratio_code;
        logic [1:0] width_code;
        chan_e      chan;
        logic       aligned;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_DEFAULT = '{
        div_code:   3'd5,
        ratio_code: 4'd0,
        width_code: 2'd1,
        chan:       CH_STEREO,
        aligned:    1'b0
    };

    // Divider code to master-clock period in reference cycles.
    function automatic logic [DIV_W-1:0] div_of(input logic [2:0] code);
        case (code)
            3'd0:    return DIV_W'(8);
            3'd1:    return DIV_W'(10);
            3'd2:    return DIV_W'(15);
            3'd3:    return DIV_W'(16);
            3'd4:    return DIV_W'(21);
            3'd5:    return DIV_W'(32);
            3'd6:    return DIV_W'(63);
            default: return DIV_W'(125);
        endcase
    endfunction

    // Ratio code to ratio: even codes 32<<k, odd codes 48<<k, k = code/2.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code);
        logic [RATIO_W-1:0] base;
        base = code[0] ? RATIO_W'(48) : RATIO_W'(32);
        return base << code[3:1];
    endfunction

    // Width code to sample width in bits: 8 * (code + 1).
    function automatic logic [WID_W-1:0] width_of(input logic [1:0] code);
        return WID_W'({code, 3'b000}) + WID_W'(8);
    endfunction

    // Legality of a requested setting.
    function automatic logic cfg_ok(input logic [3:0] ratio_code,
                                    input logic [1:0] width_code,
                                    input chan_e      chan);
        logic [RATIO_W-1:0] need;
        need = RATIO_W'(width_of(width_code)) << 1;
        return (ratio_code <= 4'd8) && (width_code != 2'd3) &&
               (chan != CH_RSVD) && (ratio_of(ratio_code) >= need);
    endfunction

endpackage

// File: rtl/i2s_cfg_latch.sv
// Holds the configuration in use. The requested configuration is taken only
// on a frame-boundary load, and only when it is legal. Assumes load_i comes
// from the frame timer and is high for one cycle per frame start.
module i2s_cfg_latch
    import i2s_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  clk_cfg_t cfg_i,
    output clk_cfg_t act_o,
    output logic     lead_word_o,
    output logic     bad_o
);

    clk_cfg_t act_q;
    clk_cfg_t act_nxt;

    // Legality of the requested setting, independent of timing.
    assign bad_o = !cfg_ok(cfg_i.ratio_code, cfg_i.width_code, cfg_i.chan);

    // Value the active configuration takes at the next edge.
    always_comb begin
        act_nxt = act_q;
        if (load_i && !bad_o) begin
            act_nxt = cfg_i;
        end
    end

    // Whether the frame about to start opens with a left-word MSB.
    assign lead_word_o = act_nxt.aligned && (act_nxt.chan != CH_RIGHT);

    // Active configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= CFG_DEFAULT;
        end else begin
            act_q <= act_nxt;
        end
    end

    assign act_o = act_q;

    p_hold_mid_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q));

    p_bad_rejected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && bad_o) |=> $stable(act_q));

    p_good_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !bad_o) |=> (act_q == $past(cfg_i)));

endmodule

// File: rtl/i2s_mck_div.sv
// Integer master-clock divider. The output is high for floor(N/2) cycles and
// low for the rest of each period. A restart forces the counter to
// phase 0, so the master clock stays aligned to the frame start.
// Assumes div_i >= 2 and changes only in a restart cycle.
module i2s_mck_div
    import i2s_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mck_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W-1:0] half;
    logic             mck_q;

    assign half = div_i >> 1;

    // Next phase of the period counter, wrapping at N-1.
    always_comb begin
        if (cnt_q == div_i - DIV_W'(1)) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt_q + DIV_W'(1);
        end
    end

    // Period counter and registered clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mck_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q <= '0;
            mck_q <= 1'b1;
        end else begin
            cnt_q <= cnt_n;
            mck_q <= (cnt_n < half);
        end
    end

    assign mck_o = mck_q;

    p_mck_rise_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $rose(mck_q)) |-> (cnt_q == '0));

    p_mck_fall_at_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $fell(mck_q)) |-> (cnt_q == half));

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < div_i));

endmodule

// File: rtl/i2s_frame_timer.sv
// Bit-clock and frame-clock timer, counted directly in reference cycles.
// Each cycle an accumulator adds 4W. Each time it passes the frame length
// (divisor x ratio), the bit clock toggles. This gives 4W half periods per
// frame for any ratio and divisor. The 4W-th toggle closes the frame and
// raises load_o. Assumes divisor x ratio >= 4W.
module i2s_frame_timer
    import i2s_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  clk_cfg_t act_i,
    input  logic     lead_word_i,
    output logic     load_o,
    output logic     sck_o,
    output logic     lrck_o,
    output logic     frame_o,
    output logic     word_o,
    output logic     active_o
);

    logic [FRAME_W-1:0] frame_len;
    logic [FRAME_W-1:0] acc_q;
    logic [FRAME_W:0]   acc_sum;
    logic [WID_W-1:0]   width;
    logic [HALF_W-1:0]  four_w;
    logic [HALF_W-1:0]  two_w;
    logic [HALF_W-1:0]  hb_q;
    logic [HALF_W-1:0]  k_next;
    logic [HALF_W-1:0]  left_slot;
    logic [HALF_W-1:0]  right_slot;
    logic               step;
    logic               frame_end;
    logic               left_on;
    logic               right_on;
    logic               started_q;
    logic               sck_q;
    logic               lrck_q;
    logic               frame_q;
    logic               word_q;

    // Frame geometry derived from the active configuration.
    assign width     = width_of(act_i.width_code);
    assign frame_len = FRAME_W'(div_of(act_i.div_code)) * FRAME_W'(ratio_of(act_i.ratio_code));
    assign four_w    = HALF_W'(width) << 2;
    assign two_w     = HALF_W'(width) << 1;

    // Toggle indices at which an active word's MSB slot begins.
    assign left_slot  = act_i.aligned ? HALF_W'(0) : HALF_W'(2);
    assign right_slot = act_i.aligned ? two_w : two_w + HALF_W'(2);
    assign left_on    = (act_i.chan != CH_RIGHT);
    assign right_on   = (act_i.chan != CH_LEFT);

    // Accumulator step decision and frame close.
    assign acc_sum   = {1'b0, acc_q} + (FRAME_W + 1)'(four_w);
    assign step      = (acc_sum >= {1'b0, frame_len});
    assign k_next    = hb_q + HALF_W'(1);
    assign frame_end = step && (k_next == four_w);
    assign load_o    = run_i && (!started_q || frame_end);

    // Timing state: accumulator, half-bit count, clocks and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            started_q <= 1'b0;
            acc_q     <= '0;
            hb_q      <= '0;
            sck_q     <= 1'b0;
            lrck_q    <= 1'b0;
            frame_q   <= 1'b0;
            word_q    <= 1'b0;
        end else if (load_o) begin
            started_q <= 1'b1;
            acc_q     <= '0;
            hb_q      <= '0;
            sck_q     <= 1'b0;
            lrck_q    <= 1'b0;
            frame_q   <= 1'b1;
            word_q    <= lead_word_i;
        end else if (step) begin
            acc_q   <= FRAME_W'(acc_sum - {1'b0, frame_len});
            hb_q    <= k_next;
            sck_q   <= ~sck_q;
            frame_q <= 1'b0;
            if (k_next == two_w) begin
                lrck_q <= 1'b1;
            end
            word_q  <= (left_on && (k_next == left_slot)) ||
                       (right_on && (k_next == right_slot));
        end else begin
            acc_q   <= FRAME_W'(acc_sum);
            frame_q <= 1'b0;
            word_q  <= 1'b0;
        end
    end

    assign sck_o    = sck_q;
    assign lrck_o   = lrck_q;
    assign frame_o  = frame_q;
    assign word_o   = word_q;
    assign active_o = started_q;

    p_lrck_on_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_q) |-> !sck_q);

    p_frame_on_lrck_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lrck_q) && started_q) |-> frame_q);

    p_frame_clocks_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |-> (!lrck_q && !sck_q));

    p_word_on_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_q |-> !sck_q);

    p_half_bits_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (hb_q < four_w));

endmodule

// File: rtl/i2s_clkgen.sv
// Top of the I2S master clock and frame generator. It joins the config
// latch, the master-clock divider and the frame timer. Assumes clk is the
// reference clock. In slave mode (master_en_i low) it holds everything idle
// and releases the clock pins.
module i2s_clkgen
    import i2s_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en_i,
    input  logic [2:0] div_code_i,
    input  logic [3:0] ratio_code_i,
    input  logic [1:0] width_code_i,
    input  logic [1:0] chan_mode_i,
    input  logic       aligned_i,
    output logic       mck_o,
    output logic       mck_oe_o,
    output logic       sck_o,
    output logic       sck_oe_o,
    output logic       lrck_o,
    output logic       lrck_oe_o,
    output logic       frame_start_o,
    output logic       word_start_o,
    output logic       cfg_bad_o
);

    clk_cfg_t req_cfg;
    clk_cfg_t act_cfg;
    logic     load;
    logic     lead_word;
    logic     active;

    // Gather the requested setting into one record.
    always_comb begin
        req_cfg.div_code   = div_code_i;
        req_cfg.ratio_code = ratio_code_i;
        req_cfg.width_code = width_code_i;
        req_cfg.chan       = chan_e'(chan_mode_i);
        req_cfg.aligned    = aligned_i;
    end

    i2s_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .cfg_i       (req_cfg),
        .act_o       (act_cfg),
        .lead_word_o (lead_word),
        .bad_o       (cfg_bad_o)
    );

    i2s_mck_div u_mck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (master_en_i),
        .restart_i (load),
        .div_i     (div_of(act_cfg.div_code)),
        .mck_o     (mck_o)
    );

    i2s_frame_timer u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (master_en_i),
        .act_i       (act_cfg),
        .lead_word_i (lead_word),
        .load_o      (load),
        .sck_o       (sck_o),
        .lrck_o      (lrck_o),
        .frame_o     (frame_start_o),
        .word_o      (word_start_o),
        .active_o    (active)
    );

    // Pin drivers are enabled only while a master stream is running.
    assign mck_oe_o  = active;
    assign sck_oe_o  = active;
    assign lrck_oe_o = active;

    p_slave_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |=> (!mck_o && !mck_oe_o && !sck_oe_o && !lrck_oe_o));

endmodule

// File: tb/test_i2s_clkgen.sv
module test_i2s_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [2:0] dc = 3'd5;
    logic [3:0] rc = 4'd0;
    logic [1:0] wc = 2'd1;
    logic [1:0] cm = 2'd0;
    logic       al = 1'b0;
    logic       mck, mck_oe, sck, sck_oe, lrck, lrck_oe, fs, ws, bad;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  m_len, m_mhi, m_mrise, m_srise, m_nw, m_w0, m_w1, m_lr, m_fs1;
    int  m_wait, m_prev_l;

    always #10 clk = ~clk;

    i2s_clkgen i_i2s_clkgen (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_en_i   (en),
        .div_code_i    (dc),
        .ratio_code_i  (rc),
        .width_code_i  (wc),
        .chan_mode_i   (cm),
        .aligned_i     (al),
        .mck_o         (mck),
        .mck_oe_o      (mck_oe),
        .sck_o         (sck),
        .sck_oe_o      (sck_oe),
        .lrck_o        (lrck),
        .lrck_oe_o     (lrck_oe),
        .frame_start_o (fs),
        .word_start_o  (ws),
        .cfg_bad_o     (bad)
    );

    function automatic int ediv(input int c);
        case (c)
            0: return 8;    1: return 10;   2: return 15;  3: return 16;
            4: return 21;   5: return 32;   6: return 63;  default: return 125;
        endcase
    endfunction

    function automatic int erat(input int c);
        case (c)
            0: return 32;   1: return 48;   2: return 64;  3: return 96;
            4: return 128;  5: return 192;  6: return 256; 7: return 384;
            default: return 512;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input int d, input int r, input int w, input int c, input int a);
        dc = 3'(d); rc = 4'(r); wc = 2'(w); cm = 2'(c); al = 1'(a);
    endtask

    task automatic set_cfg(input int d, input int r, input int w, input int c, input int a);
        @(negedge clk);
        drive_cfg(d, r, w, c, a);
    endtask

    // Advance to the next sample with the frame strobe high.
    task automatic wait_frame(input string req);
        m_wait = 0;
        m_prev_l = 0;
        do begin
            m_prev_l = int'(lrck);
            @(negedge clk);
            m_wait++;
        end while (!fs && m_wait < 70000);
        if (!fs) check({req, " frame start timeout"}, 0, 1);
    endtask

    // Measure one frame starting at the current frame-start sample.
    task automatic measure();
        int falls;
        bit ps, pm, pl;
        falls = -1; ps = 1'b1; pm = 1'b0; pl = 1'b0;
        m_len = 0; m_mhi = 0; m_mrise = 0; m_srise = 0;
        m_nw = 0; m_w0 = -1; m_w1 = -1; m_lr = -1; m_fs1 = -1;
        forever begin
            m_len++;
            if (mck) m_mhi++;
            if (mck && !pm) m_mrise++;
            if (!sck && ps) falls++;
            if (sck && !ps) m_srise++;
            if (lrck && !pl) m_lr = falls;
            if (ws) begin
                if (m_nw == 0) m_w0 = falls;
                else if (m_nw == 1) m_w1 = falls;
                m_nw++;
            end
            if (m_len == 2) m_fs1 = int'(fs);
            ps = sck; pm = mck; pl = lrck;
            @(negedge clk);
            if (fs || m_len > 70000) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 mck", int'(mck), 0);
        check("R1 sck/lrck", int'(sck | lrck), 0);
        check("R1 enables", int'(mck_oe | sck_oe | lrck_oe), 0);
        check("R1 strobes", int'(fs | ws), 0);
        rst_n = 1'b1;
    endtask

    // Full-frame measurement of one legal configuration.
    task automatic t_rate(input int d, input int r, input int w, input int c, input int a);
        int wd, n, lw, rw;
        set_cfg(d, r, w, c, a);
        wait_frame("R4");
        measure();
        n  = ediv(d);
        wd = 8 * (w + 1);
        lw = a ? 0 : 1;
        rw = a ? wd : wd + 1;
        check("R11 legal flag low", int'(bad), 0);
        check("R4 frame length", m_len, n * erat(r));
        check("R2 mck periods", m_mrise, erat(r));
        check("R3 mck high time", m_mhi, erat(r) * (n / 2));
        check("R5 sck rising edges", m_srise, 2 * wd);
        check("R6 lrck rise slot", m_lr, wd);
        check("R9 prior lrck high", m_prev_l, 1);
        check("R9 strobe single cycle", m_fs1, 0);
        if (c == 0) begin
            check("R8 stereo words", m_nw, 2);
            check("R7 left MSB slot", m_w0, lw);
            check("R7 right MSB slot", m_w1, rw);
        end else if (c == 1) begin
            check("R8 mono-left words", m_nw, 1);
            check("R7 left MSB slot", m_w0, lw);
        end else begin
            check("R8 mono-right words", m_nw, 1);
            check("R7 right MSB slot", m_w0, rw);
        end
    endtask

    // Config changes in the frame-start cycle and mid-frame (R10).
    task automatic t_coincide();
        set_cfg(5, 0, 1, 0, 0);
        wait_frame("R10");
        drive_cfg(1, 6, 1, 0, 1);
        measure();
        check("R10 same-cycle change keeps frame", m_len, 1024);
        measure();
        check("R10 change applied next frame", m_len, 2560);
        repeat (5) @(negedge clk);
        drive_cfg(2, 1, 1, 0, 0);
        wait_frame("R10");
        check("R10 mid-frame change keeps frame", m_wait, 2560 - 5);
        measure();
        check("R10 mid-frame change applied", m_len, 720);
    endtask

    task automatic t_invalid();
        set_cfg(5, 0, 1, 0, 0);
        wait_frame("R11");
        drive_cfg(3, 9, 1, 0, 0);
        #1 check("R11 ratio code 9 flagged", int'(bad), 1);
        wait_frame("R11");
        measure();
        check("R11 bad ratio not loaded", m_len, 1024);
        drive_cfg(3, 0, 2, 0, 0);
        #1 check("R11 ratio below 2W flagged", int'(bad), 1);
        wait_frame("R11");
        measure();
        check("R11 too-small ratio not loaded", m_len, 1024);
        drive_cfg(0, 0, 3, 0, 0);
        #1 check("R11 width code 3 flagged", int'(bad), 1);
        drive_cfg(0, 0, 1, 3, 0);
        #1 check("R11 channel mode 3 flagged", int'(bad), 1);
        drive_cfg(0, 8, 2, 0, 0);
        #1 check("R11 ratio 512 width 24 legal", int'(bad), 0);
        drive_cfg(5, 0, 1, 0, 0);
        #1 check("R11 ratio equal 2W legal", int'(bad), 0);
    endtask

    task automatic t_slave();
        int seen;
        seen = 0;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            seen = seen | int'(mck | mck_oe | sck_oe | lrck_oe | sck | lrck | fs);
            @(negedge clk);
        end
        check("R12 outputs quiet in slave mode", seen, 0);
        en = 1'b1;
        wait_frame("R12");
        check("R12 restart latency", m_wait, 1);
        measure();
        check("R12 frame after re-enable", m_len, 1024);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rate(5, 0, 1, 0, 0);   // 31250 Hz, I2S stereo
        t_rate(1, 6, 1, 0, 1);   // 12500 Hz, aligned stereo
        t_rate(7, 0, 0, 1, 0);   // 8000 Hz, 8-bit mono-left
        t_rate(2, 1, 1, 2, 1);   // ~44.1 kHz, aligned mono-right
        t_rate(4, 0, 1, 0, 0);   // ~48 kHz, ratio equals 2W
        t_rate(0, 8, 2, 0, 1);   // largest ratio, 24-bit
        t_rate(6, 3, 2, 2, 0);   // odd divisor, 24-bit mono-right
        t_coincide();
        t_invalid();
        t_slave();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule